// File: doc/BRIEF.md
# Memory command turnaround gate

This block stands between a processor-side memory request port and a DDR2-style command sequencer. A requester offers one command at a time: a read-or-write flag, a bank, a row, and two hints that report a bank conflict and a row conflict. The request is qualified by a valid strobe and moves only when the gate's ready output is high. Each accepted request comes out one cycle later as a registered command to the memory side.

The gate remembers the direction of the last command it issued and counts the cycles since that command. When a new request would turn the data bus around, ready stays low until the turnaround time for that direction has elapsed. The write-to-read time and the read-to-write time are separate parameters. A request in the same direction as the last one is never held. The requester normally waits four cycles after a direction change before it presents its next command, so a turnaround of four cycles or less costs nothing in practice. Ready also stays low from reset until the one-shot initialization and calibration sequence reports completion through a single-cycle pulse. Any later completion pulse is ignored.

The state machine has three states. `ST_CALIB` is entered at reset, and ready is low in it. `ST_OPEN` means any direction may be accepted. `ST_TURN` means a turnaround window is running. The transitions are:
- CALIB→OPEN on the first completion pulse.
- OPEN→TURN on any accepted request.
- TURN→TURN on an accepted request, which restarts the window.
- TURN→OPEN once the window for the last direction has run out and no request is accepted.

Nothing ever leads back to `ST_CALIB`.

Top module: `mem_turnaround_gate`

## Requirements
- R1: From reset until the cycle after the first `init_done` pulse, `req_ready` is 0 and no command is issued, even if `req_valid` is high.
- R2: `req_ready` is 1 in the cycle after the first `init_done` pulse, provided no request is pending.
- R3: A later `init_done` pulse has no effect: it neither lowers nor raises `req_ready`.
- R4: A request transfers only in a cycle where `req_valid` and `req_ready` are both 1. In the next cycle, and for that cycle only, `cmd_valid` is 1. The command carries `cmd_is_read`, `cmd_bank`, `cmd_row`, `cmd_bank_conflict` and `cmd_row_conflict`, taken from the request.
- R5: Once calibrated, a request whose direction matches the last issued command always sees `req_ready` = 1. The encoding of `req_rd_n_wr` is 1 for read and 0 for write.
- R6: Let a write transfer in cycle A. A read presented in cycle A+k sees `req_ready` = 1 only if k >= `WR2RD_CYC`; otherwise it sees 0.
- R7: Let a read transfer in cycle A. A write presented in cycle A+k sees `req_ready` = 1 only if k >= `RD2WR_CYC`; otherwise it sees 0.
- R8: The turnaround window is timed from the most recent transfer. A same-direction transfer restarts it.
- R9: The first request after calibration is accepted at once, whatever its direction.
- R10: With `RD2WR_CYC` = 2, a write presented four cycles after a read transfer is accepted without `req_ready` dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | One-cycle pulse when initialization and calibration complete |
| req_valid | input | 1 | Request strobe |
| req_rd_n_wr | input | 1 | 1 = read, 0 = write |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_bank_conflict | input | 1 | Bank-conflict hint |
| req_row_conflict | input | 1 | Row-conflict hint |
| req_ready | output | 1 | Gate accepts the request this cycle |
| cmd_valid | output | 1 | Registered command strobe, one cycle per transfer |
| cmd_is_read | output | 1 | Command direction, 1 = read |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_bank_conflict | output | 1 | Forwarded bank-conflict hint |
| cmd_row_conflict | output | 1 | Forwarded row-conflict hint |

## Verification
The assertions assume that `init_done` is a clean single-cycle pulse, and that the request fields are meaningful whenever `req_valid` is high. They do not assume that the requester keeps its four-cycle hold-off. The stimulus deliberately breaks that hold-off: it presents a reversed request in the cycle right after a transfer, and it keeps a blocked request on the port until it is taken. This exercises both sides of each window boundary. The stimulus also drives `req_valid` during calibration and sends a second completion pulse while a window is running.

// File: rtl/mem_ta_pkg.sv
package mem_ta_pkg;

    typedef enum logic [1:0] {
        ST_CALIB = 2'd0,
        ST_OPEN  = 2'd1,
        ST_TURN  = 2'd2
    } gate_state_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mem_ta_window.sv
module mem_ta_window
    import mem_ta_pkg::*;
#(
    parameter int unsigned WR2RD_CYC = 7,
    parameter int unsigned RD2WR_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_rd,
    output logic last_rd,
    output logic expired
);
    localparam int unsigned SPAN  = max_of(max_of(WR2RD_CYC, RD2WR_CYC), 1);
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] SPAN_V  = CNT_W'(SPAN);
    localparam logic [CNT_W-1:0] NEED_WR = CNT_W'(WR2RD_CYC);
    localparam logic [CNT_W-1:0] NEED_RD = CNT_W'(RD2WR_CYC);
    localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

    logic [CNT_W-1:0] elapsed_q;
    logic             last_rd_q;
    logic [CNT_W-1:0] need;

    // Cycles since the last issued command, saturating at the longest window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= SPAN_V;
            last_rd_q <= 1'b0;
        end else if (issue) begin
            elapsed_q <= ONE_V;
            last_rd_q <= issue_rd;
        end else if (elapsed_q < SPAN_V) begin
            elapsed_q <= elapsed_q + ONE_V;
        end
    end

    // A reversal away from a read needs RD2WR; away from a write needs WR2RD.
    always_comb begin
        need    = last_rd_q ? NEED_RD : NEED_WR;
        expired = (elapsed_q >= need);
        last_rd = last_rd_q;
    end

    // R6 / R7: a reversed command is never issued inside its window
    assert_reverse_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (issue_rd != last_rd_q)) |-> (elapsed_q >= need));

    // R8: every issued command restarts the window
    assert_window_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (elapsed_q == ONE_V && last_rd_q == $past(issue_rd)));

endmodule

// File: rtl/mem_ta_cmd_reg.sv
module mem_ta_cmd_reg #(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_rd,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic              in_bconf,
    input  logic              in_rconf,
    output logic              out_valid,
    output logic              out_rd,
    output logic [BANK_W-1:0] out_bank,
    output logic [ROW_W-1:0]  out_row,
    output logic              out_bconf,
    output logic              out_rconf
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rd    <= 1'b0;
            out_bank  <= '0;
            out_row   <= '0;
            out_bconf <= 1'b0;
            out_rconf <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_rd    <= in_rd;
                out_bank  <= in_bank;
                out_row   <= in_row;
                out_bconf <= in_bconf;
                out_rconf <= in_rconf;
            end
        end
    end

    // R4: an accepted request appears with its fields on the next cycle
    assert_cmd_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_valid && out_rd == $past(in_rd) && out_bank == $past(in_bank)
                  && out_row == $past(in_row) && out_bconf == $past(in_bconf)
                  && out_rconf == $past(in_rconf)));

    // R4: no command without a transfer
    assert_cmd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !out_valid);

endmodule

// File: rtl/mem_turnaround_gate.sv
module mem_turnaround_gate
    import mem_ta_pkg::*;
#(
    parameter int unsigned BANK_W    = 3,
    parameter int unsigned ROW_W     = 14,
    parameter int unsigned WR2RD_CYC = 7,
    parameter int unsigned RD2WR_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              req_valid,
    input  logic              req_rd_n_wr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_bank_conflict,
    input  logic              req_row_conflict,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic              cmd_is_read,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              cmd_bank_conflict,
    output logic              cmd_row_conflict
);
    gate_state_t state_q, state_d;
    logic        accept;
    logic        last_rd;
    logic        expired;
    logic        calib_seen_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CALIB;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CALIB: if (init_done) state_d = ST_OPEN;
            ST_OPEN:  if (accept)    state_d = ST_TURN;
            ST_TURN: begin
                if (accept)       state_d = ST_TURN;
                else if (expired) state_d = ST_OPEN;
            end
            default:  state_d = ST_CALIB;
        endcase
    end

    // Output logic
    always_comb begin
        req_ready = 1'b0;
        unique case (state_q)
            ST_CALIB: req_ready = 1'b0;
            ST_OPEN:  req_ready = 1'b1;
            ST_TURN:  req_ready = (req_rd_n_wr == last_rd) || expired;
            default:  req_ready = 1'b0;
        endcase
        accept = req_valid && req_ready;
    end

    mem_ta_window #(
        .WR2RD_CYC (WR2RD_CYC),
        .RD2WR_CYC (RD2WR_CYC)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (accept),
        .issue_rd (req_rd_n_wr),
        .last_rd  (last_rd),
        .expired  (expired)
    );

    mem_ta_cmd_reg #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_rd     (req_rd_n_wr),
        .in_bank   (req_bank),
        .in_row    (req_row),
        .in_bconf  (req_bank_conflict),
        .in_rconf  (req_row_conflict),
        .out_valid (cmd_valid),
        .out_rd    (cmd_is_read),
        .out_bank  (cmd_bank),
        .out_row   (cmd_row),
        .out_bconf (cmd_bank_conflict),
        .out_rconf (cmd_row_conflict)
    );

    // Sticky record of the completion pulse, used only by the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)         calib_seen_q <= 1'b0;
        else if (init_done) calib_seen_q <= 1'b1;
    end

    // R1: no ready before the completion pulse has been seen
    assert_no_ready_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !calib_seen_q |-> !req_ready);

    // R2: ready rises right after the first completion pulse
    assert_ready_after_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALIB && init_done) |=> req_ready);

    // R3: calibration is never re-entered
    assert_no_recalib_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CALIB) |=> (state_q != ST_CALIB));

    // R5: same-direction requests pass once calibrated
    assert_same_dir_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CALIB && req_rd_n_wr == last_rd) |-> req_ready);

    // R6: the open state is only held while the window is over
    assert_open_means_expired_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> expired);

endmodule

// File: tb/mem_turnaround_gate_bench.sv
module mem_turnaround_gate_bench;
    localparam int WR2RD  = 7;
    localparam int RD2WR  = 2;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_done = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_rd_n_wr = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic              req_bank_conflict = 1'b0;
    logic              req_row_conflict = 1'b0;
    logic              req_ready;
    logic              cmd_valid;
    logic              cmd_is_read;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic              cmd_bank_conflict;
    logic              cmd_row_conflict;

    mem_turnaround_gate #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .WR2RD_CYC(WR2RD), .RD2WR_CYC(RD2WR)
    ) u_mem_turnaround_gate (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .req_valid(req_valid), .req_rd_n_wr(req_rd_n_wr),
        .req_bank(req_bank), .req_row(req_row),
        .req_bank_conflict(req_bank_conflict), .req_row_conflict(req_row_conflict),
        .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_bank_conflict(cmd_bank_conflict), .cmd_row_conflict(cmd_row_conflict)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference model state
    int cyc = 0;
    bit calibrated = 1'b0;
    bit have_prev = 1'b0;
    bit prev_rd = 1'b0;
    int prev_cyc = 0;
    bit exp_cv = 1'b0;
    bit exp_rd = 1'b0;
    int exp_bank = 0;
    int exp_row = 0;
    bit exp_bc = 1'b0;
    bit exp_rc = 1'b0;

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(input string tag, input bit v, input bit rd, input int bank,
                        input int row, input bit bc, input bit rc, input bit pulse,
                        output bit acc);
        bit exp_rdy;
        @(negedge clk);
        check_val("R4", "cmd_valid", int'(cmd_valid), int'(exp_cv));
        if (exp_cv) begin
            check_val("R4", "cmd_is_read", int'(cmd_is_read), int'(exp_rd));
            check_val("R4", "cmd_bank", int'(cmd_bank), exp_bank);
            check_val("R4", "cmd_row", int'(cmd_row), exp_row);
            check_val("R4", "cmd_bank_conflict", int'(cmd_bank_conflict), int'(exp_bc));
            check_val("R4", "cmd_row_conflict", int'(cmd_row_conflict), int'(exp_rc));
        end
        req_valid = v;
        req_rd_n_wr = rd;
        req_bank = BANK_W'(bank);
        req_row = ROW_W'(row);
        req_bank_conflict = bc;
        req_row_conflict = rc;
        init_done = pulse;
        #1;
        exp_rdy = calibrated && (!have_prev || rd == prev_rd ||
                  (cyc - prev_cyc) >= (prev_rd ? RD2WR : WR2RD));
        check_val(tag, "req_ready", int'(req_ready), int'(exp_rdy));
        acc = v && exp_rdy;
        exp_cv = acc;
        if (acc) begin
            exp_rd = rd; exp_bank = bank % (1 << BANK_W); exp_row = row % (1 << ROW_W);
            exp_bc = bc; exp_rc = rc;
            have_prev = 1'b1; prev_rd = rd; prev_cyc = cyc;
        end
        if (pulse) calibrated = 1'b1;
        cyc++;
    endtask

    task automatic idle(input string tag, input int n, input bit pulse);
        bit a;
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, pulse, a);
    endtask

    task automatic present(input string tag, input bit rd, input int bank, input int row,
                           input bit bc, input bit rc, input int max_tries);
        bit a;
        a = 1'b0;
        for (int i = 0; i < max_tries && !a; i++) step(tag, 1'b1, rd, bank, row, bc, rc, 1'b0, a);
        check_val(tag, "taken", int'(a), 1);
    endtask

    initial begin
        bit a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle and pending requests during calibration
        idle("R1", 3, 1'b0);
        step("R1", 1'b1, 1'b0, 2, 100, 1'b0, 1'b0, 1'b0, a);
        step("R1", 1'b1, 1'b1, 3, 101, 1'b1, 1'b0, 1'b1, a);   // completion pulse
        idle("R2", 2, 1'b0);
        // R9: first command is a read, taken at once
        step("R9", 1'b1, 1'b1, 1, 5, 1'b0, 1'b1, 1'b0, a);
        // R10: write four cycles after the read
        idle("R10", 3, 1'b0);
        step("R10", 1'b1, 1'b0, 4, 77, 1'b1, 1'b1, 1'b0, a);
        // R5: back-to-back writes
        step("R5", 1'b1, 1'b0, 5, 1234, 1'b0, 1'b0, 1'b0, a);
        step("R5", 1'b1, 1'b0, 6, 16383, 1'b1, 1'b0, 1'b0, a);
        step("R5", 1'b1, 1'b0, 7, 0, 1'b0, 1'b1, 1'b0, a);
        // R6: read right after a write, held until the window passes
        present("R6", 1'b1, 2, 999, 1'b1, 1'b0, 12);
        // R7: write right after a read
        present("R7", 1'b0, 3, 42, 1'b0, 1'b1, 6);
        // R8: second write restarts the write-to-read window
        idle("R8", 4, 1'b0);
        step("R8", 1'b1, 1'b0, 1, 8, 1'b0, 0, 1'b0, a);
        present("R8", 1'b1, 0, 9, 1'b1, 1'b1, 12);
        // R3: a second completion pulse during a running window
        step("R3", 1'b1, 1'b0, 2, 55, 1'b0, 1'b0, 1'b1, a);
        present("R3", 1'b0, 2, 55, 1'b0, 1'b0, 6);
        idle("R3", 2, 1'b1);
        present("R3", 1'b1, 6, 300, 1'b0, 1'b0, 12);
        idle("R4", 2, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule